// File: doc/BRIEF.md
# Dual-Channel DAC Code Register Front End

This block sits between a byte-wide register write port and two 12-bit digital-to-analog converter cores. Each channel has a low data byte register and a high data byte register. A shared control register sets, per channel, the sample width, the output range and power-down. The block drives one 12-bit output code per channel, plus the range-select and power-down bits that the analog side consumes.

A channel's output code normally changes on the clock edge that takes in a write to its low byte. A high byte written beforehand only waits in a holding register. Software can clear the control register's live bit. While that bit is clear, data byte writes only fill the holding registers. A later control write with the live bit set loads both channels on the same edge, so both analog outputs change together. In 8-bit mode a channel uses only its low byte and places it at the top of the code.

Top module: `dual_dac_regif`

## Requirements
- R1: After reset both output codes are 0x000, range_sel and pwr_down are 0, the live bit (control bit 7) is 1 and both channels are in 12-bit mode.
- R2: The register address map is: 0 control, 1 channel A low, 2 channel A high, 3 channel B low, 4 channel B high. With live set and 12-bit mode, a low byte write loads the code as {held high[3:0], written low[7:0]} one clock after the write.
- R3: A write to a high byte register changes no output code. It only updates that channel's holding register.
- R4: In 8-bit mode (control bit 0 for channel A, bit 1 for channel B) a code load uses {low[7:0], 4'b0000}.
- R5: While the live bit is 0, low byte writes change no output code.
- R6: A control write with bit 7 set loads both channels' codes from their holding registers on the same clock. The width used is the one in the value being written.
- R7: range_sel[i] follows control bit 2+i and pwr_down[i] follows control bit 4+i, one clock after the control write.
- R8: Writes to addresses 5 to 7 change no output and no holding register.
- R9: A write to one channel's byte registers never changes the other channel's code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Write data byte |
| code_a | output | 12 | Channel A converter code |
| code_b | output | 12 | Channel B converter code |
| range_sel | output | 2 | Per-channel range select (1 = supply, 0 = reference) |
| pwr_down | output | 2 | Per-channel power-down |

## Verification
The bench uses the default parameters: two channels, 8-bit bytes and 12-bit codes. This gives 4 bits of the high byte in play, and the high nibble written to the ignored top bits proves they are dropped. Because the widths are fixed, the bench can spell every code out in full. That covers left-justified 8-bit loads, deferred loads with the live bit cleared, and simultaneous release. It also covers switching widths within the same control write that releases the holding registers.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
    localparam int CH_NUM   = 2;
    localparam int BYTE_W   = 8;
    localparam int CODE_W   = 12;
    localparam int HI_W     = CODE_W - BYTE_W;
    localparam int PAD_W    = CODE_W - BYTE_W;
    localparam int ADDR_W   = 3;

    // control register field positions
    localparam int MODE8_LSB = 0;
    localparam int RANGE_LSB = MODE8_LSB + CH_NUM;
    localparam int PD_LSB    = RANGE_LSB + CH_NUM;
    localparam int LIVE_BIT  = BYTE_W - 1;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = '0;

    typedef struct packed {
        logic [CH_NUM-1:0] mode8;
        logic [CH_NUM-1:0] range;
        logic [CH_NUM-1:0] pd;
        logic              live;
    } ctrl_t;

    function automatic logic [ADDR_W-1:0] lo_addr(input int ch);
        return ADDR_W'(1 + 2 * ch);
    endfunction

    function automatic logic [ADDR_W-1:0] hi_addr(input int ch);
        return ADDR_W'(2 + 2 * ch);
    endfunction

    function automatic logic [CODE_W-1:0] form_code(
        input logic [HI_W-1:0]   hi,
        input logic [BYTE_W-1:0] lo,
        input logic              m8
    );
        if (m8)
            return {lo, {PAD_W{1'b0}}};
        return {hi, lo};
    endfunction
endpackage

// File: rtl/dacif_decode.sv
module dacif_decode
    import dacif_pkg::*;
(
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              ctrl_we,
    output logic [CH_NUM-1:0] lo_we,
    output logic [CH_NUM-1:0] hi_we
);
    assign ctrl_we = wr_en && (wr_addr == ADDR_CTRL);

    for (genvar i = 0; i < CH_NUM; i++) begin : g_dec
        assign lo_we[i] = wr_en && (wr_addr == lo_addr(i));
        assign hi_we[i] = wr_en && (wr_addr == hi_addr(i));
    end
endmodule

// File: rtl/dacif_ctrl.sv
module dacif_ctrl
    import dacif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_we,
    input  logic [BYTE_W-1:0] wr_data,
    output ctrl_t             ctrl_q,
    output logic [CH_NUM-1:0] mode8_eff,
    output logic              xfer
);
    ctrl_t ctrl_d;

    always_comb begin
        ctrl_d.mode8 = wr_data[MODE8_LSB +: CH_NUM];
        ctrl_d.range = wr_data[RANGE_LSB +: CH_NUM];
        ctrl_d.pd    = wr_data[PD_LSB +: CH_NUM];
        ctrl_d.live  = wr_data[LIVE_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '{mode8: '0, range: '0, pd: '0, live: 1'b1};
        end else if (ctrl_we) begin
            ctrl_q <= ctrl_d;
        end
    end

    // width used for a load happening this cycle: a control write applies its own value
    assign mode8_eff = ctrl_we ? ctrl_d.mode8 : ctrl_q.mode8;
    assign xfer      = ctrl_we && ctrl_d.live;
endmodule

// File: rtl/dacif_channel.sv
module dacif_channel
    import dacif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              lo_we,
    input  logic              hi_we,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              mode8,
    input  logic              live,
    input  logic              xfer,
    output logic [CODE_W-1:0] code
);
    logic [BYTE_W-1:0] lo_hold;
    logic [HI_W-1:0]   hi_hold;
    logic              load_now;
    logic [BYTE_W-1:0] lo_src;

    assign load_now = (lo_we && live) || xfer;
    assign lo_src   = lo_we ? wr_data : lo_hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_hold <= '0;
            hi_hold <= '0;
            code    <= '0;
        end else begin
            if (lo_we)    lo_hold <= wr_data;
            if (hi_we)    hi_hold <= wr_data[HI_W-1:0];
            if (load_now) code    <= form_code(hi_hold, lo_src, mode8);
        end
    end
endmodule

// File: rtl/dual_dac_regif.sv
module dual_dac_regif
    import dacif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [CODE_W-1:0] code_a,
    output logic [CODE_W-1:0] code_b,
    output logic [CH_NUM-1:0] range_sel,
    output logic [CH_NUM-1:0] pwr_down
);
    logic              ctrl_we;
    logic [CH_NUM-1:0] lo_we;
    logic [CH_NUM-1:0] hi_we;
    ctrl_t             ctrl_q;
    logic [CH_NUM-1:0] mode8_eff;
    logic              xfer;
    logic [CODE_W-1:0] ch_code [CH_NUM];

    dacif_decode u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .ctrl_we (ctrl_we),
        .lo_we   (lo_we),
        .hi_we   (hi_we)
    );

    dacif_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .ctrl_we   (ctrl_we),
        .wr_data   (wr_data),
        .ctrl_q    (ctrl_q),
        .mode8_eff (mode8_eff),
        .xfer      (xfer)
    );

    for (genvar i = 0; i < CH_NUM; i++) begin : g_ch
        dacif_channel u_ch (
            .clk     (clk),
            .rst     (rst),
            .lo_we   (lo_we[i]),
            .hi_we   (hi_we[i]),
            .wr_data (wr_data),
            .mode8   (mode8_eff[i]),
            .live    (ctrl_q.live),
            .xfer    (xfer),
            .code    (ch_code[i])
        );
    end

    assign code_a    = ch_code[0];
    assign code_b    = ch_code[1];
    assign range_sel = ctrl_q.range;
    assign pwr_down  = ctrl_q.pd;
endmodule

// File: rtl/dacif_chk.sv
module dacif_chk
    import dacif_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [BYTE_W-1:0] wr_data,
    input logic              live,
    input logic [CH_NUM-1:0] mode8,
    input logic [CODE_W-1:0] code_a,
    input logic [CODE_W-1:0] code_b,
    input logic [CH_NUM-1:0] range_sel,
    input logic [CH_NUM-1:0] pwr_down
);
    // R2
    lo_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == lo_addr(0) && live && !mode8[0])
        |=> code_a[BYTE_W-1:0] == $past(wr_data));

    // R3
    hi_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_addr == hi_addr(0) || wr_addr == hi_addr(1)))
        |=> ($stable(code_a) && $stable(code_b)));

    // R5
    held_lo_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !live && (wr_addr == lo_addr(0) || wr_addr == lo_addr(1)))
        |=> ($stable(code_a) && $stable(code_b)));

    // R7
    field_map_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_CTRL)
        |=> (range_sel == $past(wr_data[RANGE_LSB +: CH_NUM]) &&
             pwr_down  == $past(wr_data[PD_LSB +: CH_NUM])));

    // R8
    unmapped_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr > hi_addr(CH_NUM-1))
        |=> ($stable(code_a) && $stable(code_b) &&
             $stable(range_sel) && $stable(pwr_down)));

    // R9
    isolate_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_addr == lo_addr(0) || wr_addr == hi_addr(0)))
        |=> $stable(code_b));
endmodule

bind dual_dac_regif dacif_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .live      (ctrl_q.live),
    .mode8     (ctrl_q.mode8),
    .code_a    (code_a),
    .code_b    (code_b),
    .range_sel (range_sel),
    .pwr_down  (pwr_down)
);

// File: tb/tb_dual_dac_regif.sv
module tb_dual_dac_regif;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [2:0]  wr_addr;
    logic [7:0]  wr_data;
    logic [11:0] code_a;
    logic [11:0] code_b;
    logic [1:0]  range_sel;
    logic [1:0]  pwr_down;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_dac_regif dut (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .code_a    (code_a),
        .code_b    (code_b),
        .range_sel (range_sel),
        .pwr_down  (pwr_down)
    );

    task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%03h expected=%03h", req, act, exp);
        end
    endtask

    // drive on a falling edge, result visible at the following falling edge
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 code_a", code_a, 12'h000);
        chk("R1 code_b", code_b, 12'h000);
        chk("R1 range", {10'd0, range_sel}, 12'h000);
        chk("R1 pd", {10'd0, pwr_down}, 12'h000);
    endtask

    task automatic t_live12();
        wr(3'd2, 8'hA5);
        chk("R3 hi write", code_a, 12'h000);
        wr(3'd1, 8'h3C);
        chk("R2 live 12b A", code_a, 12'h53C);
        wr(3'd4, 8'hF7);
        chk("R3 hi write B", code_b, 12'h000);
        wr(3'd3, 8'h81);
        chk("R2 live 12b B", code_b, 12'h781);
        chk("R9 A untouched", code_a, 12'h53C);
    endtask

    task automatic t_mode8();
        wr(3'd0, 8'h81);
        chk("R6 xfer A 8b", code_a, 12'h3C0);
        chk("R6 xfer B 12b", code_b, 12'h781);
        wr(3'd1, 8'hE2);
        chk("R4 8b load A", code_a, 12'hE20);
        chk("R9 B untouched", code_b, 12'h781);
    endtask

    task automatic t_fields();
        wr(3'd0, 8'h9C);
        chk("R7 range", {10'd0, range_sel}, 12'h003);
        chk("R7 pd", {10'd0, pwr_down}, 12'h001);
        chk("R6 width switch A", code_a, 12'h5E2);
    endtask

    task automatic t_sync();
        wr(3'd0, 8'h00);
        chk("R7 range cleared", {10'd0, range_sel}, 12'h000);
        chk("R5 no xfer A", code_a, 12'h5E2);
        wr(3'd2, 8'h01);
        wr(3'd1, 8'h11);
        wr(3'd4, 8'h02);
        wr(3'd3, 8'h22);
        chk("R5 held A", code_a, 12'h5E2);
        chk("R5 held B", code_b, 12'h781);
        wr(3'd0, 8'h80);
        chk("R6 release A", code_a, 12'h111);
        chk("R6 release B", code_b, 12'h222);
    endtask

    task automatic t_unmapped();
        wr(3'd5, 8'hFF);
        wr(3'd6, 8'hFF);
        wr(3'd7, 8'hFF);
        chk("R8 code_a", code_a, 12'h111);
        chk("R8 code_b", code_b, 12'h222);
        chk("R8 fields", {8'd0, range_sel, pwr_down}, 12'h000);
        wr(3'd1, 8'h00);
        chk("R8 hold A intact", code_a, 12'h100);
    endtask

    task automatic t_both8();
        wr(3'd0, 8'h83);
        chk("R4 both 8b A", code_a, 12'h000);
        chk("R4 both 8b B", code_b, 12'h220);
    endtask

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_live12();
        t_mode8();
        t_fields();
        t_sync();
        t_unmapped();
        t_both8();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule